// File: doc/BRIEF.md
# Floppy Interface Edge-Latched Status Register

This block produces the 8-bit read-only status byte that a floppy disk controller offers for its drive-cable interface. Two bits mirror the live, active-low drive-select outputs for drives 0 and 1. Three bits are sticky capture flags: the first records that the write-gate line became active, and the other two record that the read-data or write-data cable line returned to its idle (high) level. Bits 0, 1 and 7 stand for drive selects and a drive input that this controller does not have, and they always read as one.

The three cable lines are asynchronous to the system clock. Each passes through a two-flop synchronizer, and then an edge detector compares the synchronized level with its value one cycle earlier. Each capture flag is a two-state machine. `CAP_IDLE` moves to `CAP_HELD` when its edge is detected (transition *capture*). `CAP_HELD` moves back to `CAP_IDLE` only when a read of the digital input register is strobed with no new edge in the same cycle (transition *clear*). In every other case a flag keeps its state (transition *hold*), and a same-cycle edge wins over a clear. A read of this status register itself does not clear the flags. A host read port returns the byte when the status register is selected with read-enable high.

Top module: `fdc_iface_status`

## Requirements
- R1: While reset is asserted and right after it is released with the cable lines idle (write gate 0, read data 1, write data 1), bits 2, 3 and 4 of `status_o` are 0 and bits 0 and 1 are 1.
- R2: Bits 0, 1 and 7 of `status_o` read as 1 at all times, whatever the inputs are.
- R3: A rising edge on `wgate_i` sets bit 2 on the third clock edge after the new level is first sampled. A falling edge on `wgate_i` does not set bit 2.
- R4: A rising edge on `rdata_n_i` (return to idle) sets bit 3 with the same three-edge latency. A falling edge does not set it.
- R5: A rising edge on `wdata_n_i` sets bit 4 with the same latency, whatever level `wgate_i` has. A falling edge does not set it.
- R6: A cycle with `host_rd_en_i` and `dir_sel_i` both high clears bits 2, 3 and 4 on the next clock edge.
- R7: A read of this register (`host_rd_en_i` and `stat_sel_i` high, `dir_sel_i` low) does not change bits 2 to 4. A set flag also stays set through further toggles of its line until it is cleared.
- R8: If a flag's capture edge and a clearing read fall in the same cycle, that flag ends up set, while the other flags are still cleared.
- R9: Bit 5 equals `ds0_n_i` and bit 6 equals `ds1_n_i`, with no clock delay.
- R10: `host_rdata_o` equals `status_o` in any cycle where `host_rd_en_i` and `stat_sel_i` are both high. Otherwise it is 8'h00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wgate_i | input | 1 | Write-gate cable line, active high, asynchronous |
| rdata_n_i | input | 1 | Read-data cable line, active low, asynchronous |
| wdata_n_i | input | 1 | Write-data cable line, active low, asynchronous |
| ds0_n_i | input | 1 | Drive select 0, active low |
| ds1_n_i | input | 1 | Drive select 1, active low |
| host_rd_en_i | input | 1 | Host read strobe, one cycle |
| stat_sel_i | input | 1 | Address decode hit for this status register |
| dir_sel_i | input | 1 | Address decode hit for the digital input register |
| status_o | output | 8 | Status byte |
| host_rdata_o | output | 8 | Read data: the status byte when selected, else zero |

## Verification
On every cycle, the assertions check the flag state machines. A detected edge always leaves its flag held on the next cycle. A clear with no edge drops a held flag. With neither an edge nor a clear, the flag does not move. At the top level, a rising write-gate or read-data flag must trace back to a high input sampled three cycles earlier. Only the bench scenarios can show the rest: the exact capture latency, that falling edges are ignored, that reading this register leaves the flags in place, the same-cycle clear and capture race, and the constant and live bits over every drive-select and select-strobe combination.

// File: rtl/fdc_stat_pkg.sv
package fdc_stat_pkg;

    localparam int STAT_W  = 8;
    localparam int NUM_CAP = 3;

    // bit positions within the status byte
    localparam int BIT_NDS2  = 0;
    localparam int BIT_NDS3  = 1;
    localparam int BIT_CAP0  = 2;
    localparam int BIT_NDS0  = 5;
    localparam int BIT_NDS1  = 6;
    localparam int BIT_NDRV2 = 7;

    typedef enum logic {
        CAP_IDLE = 1'b0,
        CAP_HELD = 1'b1
    } cap_state_e;

    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } edge_kind_e;

    // channel 0: write gate (active high, capture on activation)
    // channels 1,2: read/write data (active low, capture on return to idle)
    function automatic edge_kind_e cap_edge(input int idx);
        case (idx)
            0:       return EDGE_RISE;
            default: return EDGE_RISE;
        endcase
    endfunction

    function automatic logic cap_idle_lvl(input int idx);
        case (idx)
            0:       return 1'b0;
            default: return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/fdc_sync2.sv
module fdc_sync2 #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    logic meta_q;
    logic stab_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            stab_q <= RST_VAL;
        end else begin
            meta_q <= d_i;
            stab_q <= meta_q;
        end
    end

    assign q_o = stab_q;

endmodule

// File: rtl/fdc_edge_flag.sv
module fdc_edge_flag
    import fdc_stat_pkg::*;
#(
    parameter edge_kind_e KIND     = EDGE_RISE,
    parameter logic       IDLE_LVL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    input  logic clr_i,
    output logic flag_o
);

    logic       prev_q;
    logic       hit;
    cap_state_e state_q;
    cap_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= IDLE_LVL;
        else        prev_q <= lvl_i;
    end

    generate
        if (KIND == EDGE_RISE) begin : g_rise
            assign hit = lvl_i & ~prev_q;
        end else begin : g_fall
            assign hit = ~lvl_i & prev_q;
        end
    endgenerate

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CAP_IDLE;
        else        state_q <= state_d;
    end

    // next state: capture beats clear
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CAP_IDLE: if (hit)              state_d = CAP_HELD;
            CAP_HELD: if (clr_i && !hit)    state_d = CAP_IDLE;
            default:                        state_d = CAP_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        unique case (state_q)
            CAP_HELD: flag_o = 1'b1;
            default:  flag_o = 1'b0;
        endcase
    end

    // R8
    set_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (state_q == CAP_HELD));

    // R6
    clear_drops_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !hit && state_q == CAP_HELD) |=> (state_q == CAP_IDLE));

    // R7
    hold_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit && !clr_i) |=> $stable(state_q));

endmodule

// File: rtl/fdc_iface_status.sv
module fdc_iface_status
    import fdc_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wgate_i,
    input  logic              rdata_n_i,
    input  logic              wdata_n_i,
    input  logic              ds0_n_i,
    input  logic              ds1_n_i,
    input  logic              host_rd_en_i,
    input  logic              stat_sel_i,
    input  logic              dir_sel_i,
    output logic [STAT_W-1:0] status_o,
    output logic [STAT_W-1:0] host_rdata_o
);

    logic [NUM_CAP-1:0] raw_lines;
    logic [NUM_CAP-1:0] sync_lines;
    logic [NUM_CAP-1:0] cap_flags;
    logic               dir_clr;
    logic               stat_rd;

    assign raw_lines = {wdata_n_i, rdata_n_i, wgate_i};
    assign dir_clr   = host_rd_en_i & dir_sel_i;
    assign stat_rd   = host_rd_en_i & stat_sel_i;

    generate
        for (genvar ch = 0; ch < NUM_CAP; ch++) begin : g_cap
            fdc_sync2 #(
                .RST_VAL (cap_idle_lvl(ch))
            ) sync_i (
                .clk   (clk),
                .rst_n (rst_n),
                .d_i   (raw_lines[ch]),
                .q_o   (sync_lines[ch])
            );

            fdc_edge_flag #(
                .KIND     (cap_edge(ch)),
                .IDLE_LVL (cap_idle_lvl(ch))
            ) flag_i (
                .clk    (clk),
                .rst_n  (rst_n),
                .lvl_i  (sync_lines[ch]),
                .clr_i  (dir_clr),
                .flag_o (cap_flags[ch])
            );
        end
    endgenerate

    always_comb begin
        status_o                            = '0;
        status_o[BIT_NDS2]                  = 1'b1;
        status_o[BIT_NDS3]                  = 1'b1;
        status_o[BIT_CAP0+NUM_CAP-1:BIT_CAP0] = cap_flags;
        status_o[BIT_NDS0]                  = ds0_n_i;
        status_o[BIT_NDS1]                  = ds1_n_i;
        status_o[BIT_NDRV2]                 = 1'b1;
    end

    assign host_rdata_o = stat_rd ? status_o : '0;

    // R3
    wgate_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o[BIT_CAP0]) |-> $past(wgate_i, 3));

    // R4
    rdata_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o[BIT_CAP0+1]) |-> $past(rdata_n_i, 3));

endmodule

// File: tb/fdc_iface_status_tb_top.sv
module fdc_iface_status_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wgate_i = 1'b0;
    logic       rdata_n_i = 1'b1;
    logic       wdata_n_i = 1'b1;
    logic       ds0_n_i = 1'b1;
    logic       ds1_n_i = 1'b1;
    logic       host_rd_en_i = 1'b0;
    logic       stat_sel_i = 1'b0;
    logic       dir_sel_i = 1'b0;
    logic [7:0] status_o;
    logic [7:0] host_rdata_o;

    int n_checks = 0;
    int n_fail   = 0;
    logic [2:0] mdl_flags = 3'b000;

    always #2 clk = ~clk;

    fdc_iface_status dut_i (
        .clk(clk), .rst_n(rst_n),
        .wgate_i(wgate_i), .rdata_n_i(rdata_n_i), .wdata_n_i(wdata_n_i),
        .ds0_n_i(ds0_n_i), .ds1_n_i(ds1_n_i),
        .host_rd_en_i(host_rd_en_i), .stat_sel_i(stat_sel_i), .dir_sel_i(dir_sel_i),
        .status_o(status_o), .host_rdata_o(host_rdata_o)
    );

    function automatic logic [7:0] exp_status();
        return {1'b1, ds1_n_i, ds0_n_i, mdl_flags, 2'b11};
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_line(input int ch, input logic active);
        case (ch)
            0:       wgate_i   = active;
            1:       rdata_n_i = ~active;
            default: wdata_n_i = ~active;
        endcase
    endtask

    task automatic dir_read();
        host_rd_en_i = 1'b1; dir_sel_i = 1'b1;
        step(1);
        host_rd_en_i = 1'b0; dir_sel_i = 1'b0;
        mdl_flags = 3'b000;
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
        $finish;
    end

    initial begin
        step(3);
        // R1: during reset
        check("R1 in reset", status_o, 8'hE3);
        rst_n = 1'b1;
        step(4);
        check("R1 after reset", status_o, 8'hE3);

        // R3 R4 R5: sweep each channel, both edges, with reads of this register (R7)
        for (int ch = 0; ch < 3; ch++) begin
            for (int wg = 0; wg < 2; wg++) begin
                if (ch == 0 && wg == 1) continue;
                wgate_i = (ch == 2) ? logic'(wg) : 1'b0;
                step(5);
                if (ch == 2 && wg == 1) mdl_flags[0] = 1'b1;
                dir_read();
                step(1);
                check("R6 clear before sweep", status_o, exp_status());
                set_line(ch, 1'b1);
                step(3);
                if (ch == 0) mdl_flags[0] = 1'b1;
                check(ch == 0 ? "R3 active edge" : "R4/R5 active edge ignored",
                      status_o, exp_status());
                host_rd_en_i = 1'b1; stat_sel_i = 1'b1;
                step(1);
                check("R10 read port", host_rdata_o, exp_status());
                host_rd_en_i = 1'b0; stat_sel_i = 1'b0;
                step(2);
                check("R7 status read keeps flags", status_o, exp_status());
                set_line(ch, 1'b0);
                step(2);
                check("R3/R4/R5 latency not early", status_o, exp_status());
                step(1);
                if (ch == 0 && !(ch == 2 && wg == 1)) ;
                if (ch == 1) mdl_flags[1] = 1'b1;
                if (ch == 2) mdl_flags[2] = 1'b1;
                check(ch == 1 ? "R4 idle edge" : (ch == 2 ? "R5 idle edge" : "R3 fall ignored"),
                      status_o, exp_status());
                // retoggle: stays set (R7)
                set_line(ch, 1'b1); step(4); set_line(ch, 1'b0); step(4);
                check("R7 stays set", status_o, exp_status());
            end
        end
        wgate_i = 1'b0;
        step(5);
        dir_read();
        check("R6 clear all", status_o, exp_status());

        // R8: collision on wgate flag while bit 4 also set
        set_line(0, 1'b1); step(5); set_line(0, 1'b0); step(5);
        set_line(2, 1'b1); step(5); set_line(2, 1'b0); step(5);
        mdl_flags = 3'b101;
        check("R8 setup", status_o, exp_status());
        set_line(0, 1'b1);
        step(2);
        host_rd_en_i = 1'b1; dir_sel_i = 1'b1;
        step(1);
        host_rd_en_i = 1'b0; dir_sel_i = 1'b0;
        mdl_flags = 3'b001;
        check("R8 capture wins clear", status_o, exp_status());
        set_line(0, 1'b0); step(5);
        dir_read();

        // R2 R9 R10: sweep drive selects and strobe combinations
        for (int v = 0; v < 32; v++) begin
            ds0_n_i = v[0]; ds1_n_i = v[1];
            host_rd_en_i = v[2]; stat_sel_i = v[3]; dir_sel_i = v[4];
            #1;
            check("R9 live selects", {status_o[6], status_o[5]}, {6'b0, ds1_n_i, ds0_n_i});
            check("R2 constant ones", {status_o[7], status_o[1:0]}, 8'h07);
            check("R10 read port", host_rdata_o,
                  (v[2] && v[3]) ? exp_status() : 8'h00);
            step(1);
        end
        host_rd_en_i = 1'b0; stat_sel_i = 1'b0; dir_sel_i = 1'b0;
        step(1);
        check("R6 flags clear after sweep", status_o, exp_status());

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule